// File: doc/BRIEF.md
# Chainable Two-Channel Waveform Timer

This block holds two identical 16-bit up-counters. Each channel advances on a selectable counting source: off, every system clock cycle, a shared prescaled tick, or the rising edge of the previous channel's waveform line. Each channel has two compare registers, RA and RC. A match on either, or a software trigger, can set, clear or toggle the channel's waveform output. Channel 0's waveform line can clock channel 1, which gives a 32-bit free-running count: the low half is in channel 0 and the high half in channel 1.

A trigger never clears a counter at once. It leaves a reset pending, and the channel zeroes on its next active counting tick. A chained high channel therefore only resets when its low neighbour's waveform rises. If channel 0's trigger action is programmed to raise its waveform, a single synchronised trigger creates that rising edge, and the pair restarts together instead of waiting for the low half to come round. All logic runs on one system clock. The counting sources act as clock enables, and software reaches every register through a simple registered read/write bus.

Top module: `tmr_pair`

## Requirements
- R1: A trigger does not clear the count directly. It marks a reset pending, and the count becomes 0 on the channel's next active tick (the trigger cycle's own tick included). Until then the count and the pending mark are held, even while the counting source is off.
- R2: On an active tick with no reset pending or arriving, the count increments by one modulo 2^16, so 0xFFFF is followed by 0.
- R3: In a cycle without an active tick, the count does not change.
- R4: An RA (RC) event occurs on an active tick whose new count equals RA (RC). Each action field is coded 00 none, 01 set, 10 clear, 11 toggle. When no event occurs, the waveform output keeps its level.
- R5: When events coincide, the trigger takes precedence over RC, and RC over RA. An event whose action is none defers to the next one down. The trigger action is applied in the trigger cycle itself, whether or not a tick is present.
- R6: Mode bits [1:0] select the counting source: 00 off, 01 system clock, 10 prescaled tick, 11 chained. A chained channel 1 ticks in the cycle after channel 0's waveform rises. Channel 0 gets no chained ticks.
- R7: Writing the control word at address 8 triggers channel 0 if bit 0 is set and channel 1 if bit 1 is set. Bit 2 triggers both channels in the same cycle.
- R8: With channel 0 chained into channel 1 and channel 0's trigger action set to "set" while its waveform is low, a bit-2 trigger zeroes channel 0 on that edge and channel 1 one cycle later.
- R9: The prescaled tick occurs on every PRE_DIV-th system clock edge after reset release, counting from that release (default PRE_DIV = 8).
- R10: Register map: address bit 3 = 0 selects a channel register, bit 2 picks the channel, and bits [1:0] pick mode (0), RA (1), RC (2) or count (3, read only). Mode bits are [1:0] source, [3:2] RA action, [5:4] RC action, [7:6] trigger action. Read data appears, with rvalid, one cycle after rd_en.
- R11: After reset, all modes, compare registers, counts and waveform outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| wave_o | output | 2 | Waveform output of each channel |

## Verification
The chained pair is driven with three trigger patterns. A synchronised trigger with channel 0's trigger action set to "set" shows the high half zeroing one cycle behind the low half. The same trigger with the action set to none shows the high half holding its old value until channel 0's RA edge, and then zeroing instead of incrementing. Channel-0-only triggers pump the high half, which shows that it counts waveform edges and is not reset. A full 65536-cycle run demonstrates the wrap and the carry into the high half. A disabled source holding a pending reset, coinciding compare and trigger events under each priority order, and a prescaled toggle whose timing the bench recomputes from the reset release cover the remaining corners.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd8;
  localparam int unsigned SYNC_BIT = NUM_CH;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_RA   = 2'd1;
  localparam logic [1:0] REG_RC   = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } wave_act_e;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_PRE   = 2'b10,
    SRC_CHAIN = 2'b11
  } cnt_src_e;

  typedef struct packed {
    wave_act_e trg_act;
    wave_act_e rc_act;
    wave_act_e ra_act;
    cnt_src_e  src;
  } chan_mode_t;

  localparam int unsigned MODE_W = $bits(chan_mode_t);

  function automatic logic apply_act(input logic cur, input wave_act_e act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // Highest-priority event whose action is not "none" decides the level.
  function automatic logic resolve_wave(input logic cur,
                                        input logic trg_ev, input wave_act_e trg_act,
                                        input logic rc_ev,  input wave_act_e rc_act,
                                        input logic ra_ev,  input wave_act_e ra_act);
    if (trg_ev && trg_act != ACT_NONE) return apply_act(cur, trg_act);
    if (rc_ev  && rc_act  != ACT_NONE) return apply_act(cur, rc_act);
    if (ra_ev  && ra_act  != ACT_NONE) return apply_act(cur, ra_act);
    return cur;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
      end

      assign tick_o = (phase_q == LAST);

      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pair_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i,
  output logic [CNT_W-1:0]               rdata,
  output logic                           rvalid,
  output chan_mode_t [NUM_CH-1:0]        mode_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   ra_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   rc_o,
  output logic [NUM_CH-1:0]              trig_o
);

  logic       chan_space;
  logic       ch_sel;
  logic [1:0] reg_sel;
  logic       ctrl_wr;
  logic [CNT_W-1:0] rd_val;
  logic [CNT_W-1:0] rdata_q;
  logic             rvalid_q;

  assign chan_space = ~addr[3];
  assign ch_sel     = addr[2];
  assign reg_sel    = addr[1:0];
  assign ctrl_wr    = wr_en && (addr == CTRL_ADDR);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && chan_space && (ch_sel == 1'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_o[c] <= '0;
          ra_o[c]   <= '0;
          rc_o[c]   <= '0;
        end else if (hit) begin
          case (reg_sel)
            REG_MODE: mode_o[c] <= chan_mode_t'(wdata[MODE_W-1:0]);
            REG_RA:   ra_o[c]   <= wdata;
            REG_RC:   rc_o[c]   <= wdata;
            default:  ;
          endcase
        end
      end

      assign trig_o[c] = ctrl_wr && (wdata[c] || wdata[SYNC_BIT]);
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (chan_space) begin
      case (reg_sel)
        REG_MODE: rd_val = CNT_W'(mode_o[ch_sel]);
        REG_RA:   rd_val = ra_o[ch_sel];
        REG_RC:   rd_val = rc_o[ch_sel];
        REG_CNT:  rd_val = cnt_i[ch_sel];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_val;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pair_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_mode_t       mode_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rc_i,
  input  logic             trig_i,
  input  logic             pre_tick_i,
  input  logic             chain_tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             pend_o
);

  logic             tick;
  logic             clear_now;
  logic             ra_hit;
  logic             rc_hit;
  logic             wave_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             pend_q;
  logic             wave_q;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic clear);
    return clear ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    case (mode_i.src)
      SRC_SYS:   tick = 1'b1;
      SRC_PRE:   tick = pre_tick_i;
      SRC_CHAIN: tick = chain_tick_i;
      default:   tick = 1'b0;
    endcase
  end

  assign clear_now = pend_q | trig_i;
  assign cnt_nxt   = step_count(cnt_q, clear_now);
  assign ra_hit    = tick && (cnt_nxt == ra_i);
  assign rc_hit    = tick && (cnt_nxt == rc_i);
  assign wave_nxt  = resolve_wave(wave_q, trig_i, mode_i.trg_act,
                                  rc_hit, mode_i.rc_act,
                                  ra_hit, mode_i.ra_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      wave_q <= wave_nxt;
      if (tick) begin
        cnt_q  <= cnt_nxt;
        pend_q <= 1'b0;
      end else if (trig_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wave_o = wave_q;
  assign pend_o = pend_q;

  p_hold_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick) |=> (pend_q && $stable(cnt_q)));

  p_reset_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pend_q || trig_i)) |=> (cnt_q == '0 && !pend_q));

  p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && !trig_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_ra_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_hit && !rc_hit && !trig_i && mode_i.ra_act == ACT_SET) |=> wave_q);

  p_rc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && !trig_i && mode_i.rc_act == ACT_CLR) |=> !wave_q);

  p_quiet_wave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !ra_hit && !rc_hit) |=> $stable(wave_q));

  p_trig_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && mode_i.trg_act == ACT_SET) |=> wave_q);

  p_trig_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && mode_i.trg_act == ACT_CLR) |=> !wave_q);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pair_pkg::*; #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              rvalid,
  output logic [NUM_CH-1:0] wave_o
);

  chan_mode_t [NUM_CH-1:0]      mode;
  logic [NUM_CH-1:0][CNT_W-1:0] ra;
  logic [NUM_CH-1:0][CNT_W-1:0] rc;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt;
  logic [NUM_CH-1:0]            trig;
  logic [NUM_CH-1:0]            pend;
  logic [NUM_CH-1:0]            wave;
  logic [NUM_CH-1:0]            chain_tick;
  logic [NUM_CH-2:0]            wave_prev_q;
  logic                         pre_tick;
  logic                         sync_wr;

  tmr_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (pre_tick)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt_i  (cnt),
    .rdata  (rdata),
    .rvalid (rvalid),
    .mode_o (mode),
    .ra_o   (ra),
    .rc_o   (rc),
    .trig_o (trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_prev_q <= '0;
    else        wave_prev_q <= wave[NUM_CH-2:0];
  end

  assign chain_tick[0] = 1'b0;

  generate
    for (genvar c = 1; c < NUM_CH; c++) begin : g_link
      assign chain_tick[c] = wave[c-1] & ~wave_prev_q[c-1];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      tmr_channel #(.CNT_W(CNT_W)) u_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode[c]),
        .ra_i         (ra[c]),
        .rc_i         (rc[c]),
        .trig_i       (trig[c]),
        .pre_tick_i   (pre_tick),
        .chain_tick_i (chain_tick[c]),
        .cnt_o        (cnt[c]),
        .wave_o       (wave[c]),
        .pend_o       (pend[c])
      );
    end
  endgenerate

  assign wave_o  = wave;
  assign sync_wr = wr_en && (addr == CTRL_ADDR) && wdata[SYNC_BIT];

  p_chain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1].src == SRC_CHAIN && $rose(wave[0]) && !pend[1] && !trig[1])
    |=> (cnt[1] == $past(cnt[1]) + 1'b1));

  p_sync_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wr |=> ((pend[0] || cnt[0] == '0) && (pend[1] || cnt[1] == '0)));

  p_chained_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_wr && mode[0].trg_act == ACT_SET && mode[1].src == SRC_CHAIN && !wave[0])
    |=> ##1 (cnt[1] == '0 && !pend[1]));

endmodule

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_DIV    = 8;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic [1:0]  wave_o;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       lbl_q[$];
  logic [15:0] mon_exp;
  string       mon_lbl;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid),
    .wave_o (wave_o)
  );

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  // Monitor: pops the scoreboard as read data arrives.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data: actual %h expected none", rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_lbl = lbl_q.pop_front();
        checks++;
        if (rdata !== mon_exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", mon_lbl, rdata, mon_exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [15:0] e, input string lbl);
    exp_q.push_back(e);
    lbl_q.push_back(lbl);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_wave(input int idx, input logic e, input string lbl);
    checks++;
    if (wave_o[idx] !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", lbl, wave_o[idx], e);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int et, t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk_wave(0, 1'b0, "R11 wave0 after reset");
    chk_wave(1, 1'b0, "R11 wave1 after reset");
    bus_rd(4'd0, 16'h0000, "R11 mode0 after reset");
    bus_rd(4'd3, 16'h0000, "R11 count0 after reset");
    bus_rd(4'd7, 16'h0000, "R11 count1 after reset");

    // Configure chained pair: ch0 RA=2 set, RC=4 clear, trigger set
    bus_wr(4'd1, 16'd2);
    bus_wr(4'd2, 16'd4);
    bus_wr(4'd4, 16'h0003);
    bus_wr(4'd0, 16'h0065);
    bus_rd(4'd1, 16'd2, "R10 RA0 readback");
    bus_rd(4'd0, 16'h0065, "R10 mode0 readback");
    idle(6);

    // R8: sync restarts both halves together
    bus_wr(4'd8, 16'h0004);
    bus_rd(4'd3, 16'd0, "R1 R7 count0 zero on trigger tick");
    bus_rd(4'd7, 16'd0, "R8 count1 zero one cycle after sync");
    idle(3);

    // R6: channel-0-only triggers clock channel 1 without resetting it
    bus_wr(4'd8, 16'h0001);
    idle(5);
    bus_wr(4'd8, 16'h0001);
    idle(1);
    bus_rd(4'd7, 16'd2, "R6 count1 follows ch0 rising edges");
    bus_rd(4'd3, 16'd2, "R2 count0 increments");

    // R1: trigger action none -> high half waits for ch0 RA edge
    bus_wr(4'd0, 16'h0025);
    bus_wr(4'd8, 16'h0004);
    bus_rd(4'd7, 16'd2, "R1 count1 holds while reset pending");
    bus_rd(4'd7, 16'd2, "R1 count1 still pending");
    idle(1);
    bus_rd(4'd7, 16'd0, "R1 count1 zero on first chained tick");
    bus_rd(4'd3, 16'd4, "R2 count0 after sync");

    // R2 wrap and carry into high half
    idle(65530);
    bus_rd(4'd3, 16'hFFFF, "R2 count0 at top");
    bus_rd(4'd3, 16'h0000, "R2 count0 wraps to zero");
    bus_rd(4'd7, 16'd0, "R6 count1 before carry edge");
    idle(1);
    bus_rd(4'd7, 16'd1, "R6 count1 after carry edge");

    // R1 R3: source off keeps the reset pending and the count frozen
    bus_wr(4'd4, 16'h0000);
    bus_wr(4'd8, 16'h0002);
    idle(2);
    bus_rd(4'd7, 16'd1, "R1 R3 count1 frozen with source off");
    bus_wr(4'd4, 16'h0001);
    bus_rd(4'd7, 16'd1, "R3 count1 before first tick");
    bus_rd(4'd7, 16'd0, "R1 count1 pending reset applied");
    bus_rd(4'd7, 16'd1, "R2 count1 counts on system clock");

    // R5 priorities on channel 0 (RA = RC = 0, hit on trigger tick)
    bus_wr(4'd1, 16'd0);
    bus_wr(4'd2, 16'd0);
    bus_wr(4'd0, 16'h0065);
    bus_wr(4'd8, 16'h0001);
    chk_wave(0, 1'b1, "R5 trigger set beats RC clear");
    bus_wr(4'd0, 16'h0025);
    bus_wr(4'd8, 16'h0001);
    chk_wave(0, 1'b0, "R5 R4 RC clear beats RA set when trigger action none");
    bus_wr(4'd0, 16'h0085);
    bus_wr(4'd8, 16'h0001);
    chk_wave(0, 1'b0, "R5 trigger clear beats RA set");

    // R9 R4: prescaled channel 1 with RA toggle
    bus_wr(4'd5, 16'd1);
    bus_wr(4'd4, 16'h000E);
    et = edge_cnt + 1;
    bus_wr(4'd8, 16'h0002);
    t0 = ((et + PRE_DIV - 1) / PRE_DIV) * PRE_DIV;
    t1 = t0 + PRE_DIV;
    t2 = t1 + PRE_DIV;
    while (edge_cnt < t1) @(negedge clk);
    chk_wave(1, 1'b1, "R4 RA toggle raises wave1");
    while (edge_cnt < t2) @(negedge clk);
    bus_rd(4'd7, 16'd2, "R9 count1 on prescaled ticks");
    chk_wave(1, 1'b1, "R4 wave1 steady without events");

    idle(4);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule